// File: doc/BRIEF.md
# Buffered Caller-Data Byte Readout

This block sits behind a 1200-baud FSK demodulator and turns the recovered bit stream into bytes that a host fetches one bit at a time. The receiver finds each character frame, drops the framing bits and keeps only the eight payload bits. Once the last payload bit has been sampled, the byte moves into an output shift register. At the same moment an active-low ready strobe goes out, and the host uses it as an interrupt.

The host reads with its own slow clock, which has no timing relation to the system clock. Each rising edge of that clock puts the next stored bit on the data output, oldest bit first. The ready strobe times itself out after half a bit period. It drops earlier if the host starts reading while it is still low. A carrier-valid input gates the whole path: without carrier no frame is taken in and no strobe is raised. A byte that lands before the host has drained the previous one replaces it and sets a sticky overrun flag.

Top module: `cid_byte_reader`

## Requirements
- R1: During and after reset, `rdy_n` is 1, `overrun` is 0 and `data_out` is 1 until the first read edge.
- R2: A frame is a low start bit, eight payload bits sent least significant first, then a high stop bit. Only the eight payload bits are kept.
- R3: `rdy_n` falls once for each accepted frame, after the eighth payload bit is sampled and before the stop bit ends.
- R4: Each rising edge of `host_rd_clk` puts the next stored bit on `data_out`, starting with payload bit 0. `data_out` changes only in response to such an edge.
- R5: A rising edge of `host_rd_clk` while `rdy_n` is low returns `rdy_n` to 1 before its half-bit time runs out.
- R6: If nothing is read, `rdy_n` stays low for exactly CLK_PER_BIT/2 system clock cycles.
- R7: Once all eight bits have been read, further rising edges of `host_rd_clk` leave `data_out` and `rdy_n` unchanged.
- R8: While `carrier_ok` is 0, no frame is accepted, `rdy_n` stays 1 and the stored byte is kept.
- R9: A byte accepted while bits of the previous byte are still unread replaces the stored byte and sets `overrun` to 1. `overrun` then stays 1 until reset.
- R10: A low pulse on `demod_bit` shorter than half a bit period is not taken as a start bit, and it produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the host read rate |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_ok | input | 1 | Carrier present; gates frame reception |
| demod_bit | input | 1 | Demodulated serial stream, synchronous to `clk` |
| host_rd_clk | input | 1 | Asynchronous host read clock; bits advance on its rising edges |
| data_out | output | 1 | Serial data bit presented to the host |
| rdy_n | output | 1 | Active-low byte-ready strobe |
| overrun | output | 1 | Sticky flag: a byte was replaced before it was fully read |

## Verification
The bench sets CLK_PER_BIT to 16. A whole frame then takes about 160 cycles, and the ready pulse lasts exactly 8 cycles. With those numbers, a read edge that arrives inside the pulse window can be told apart from the pulse expiring on its own. The host clock is held high and low for 4 system cycles each, which meets the 4x synchronizer ratio. The short frames leave enough cycles for back-to-back overrun, a carrier gap and a glitch that is too short to count as a start bit.

// File: rtl/cbr_pkg.sv
// Shared types for the buffered byte readout.
package cbr_pkg;
    // Frame receiver states, in the order a character passes through them.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/cbr_clk_sync.sv
// Brings an asynchronous clock-like input into the clk domain and
// produces a one-cycle pulse for each rising edge of that input.
// Assumes the input stays high and low for at least 2 clk cycles each.
module cbr_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/cbr_frame_rx.sv
// Finds start/8-data/stop frames in a demodulated bit stream that is
// synchronous to clk. The start bit is checked again at its middle, and
// data bits are sampled at bit centres. After the last data bit it pulses
// byte_vld for one cycle, with byte_q valid in that same cycle.
// Dropping carrier_ok aborts any frame in progress.
module cbr_frame_rx
    import cbr_pkg::*;
#(
    parameter int CLK_PER_BIT = 16,
    parameter int DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 carrier_ok,
    input  logic                 serial_in,
    output logic                 byte_vld,
    output logic [DATA_BITS-1:0] byte_q
);
    localparam int CNT_W    = $clog2(CLK_PER_BIT);
    localparam int IDX_W    = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
    localparam int HALF_BIT = CLK_PER_BIT / 2;

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;

    // Frame state machine: start check, data sampling, stop bit wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (!carrier_ok) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (!serial_in) begin
                            state <= RX_START;
                            cnt   <= CNT_W'(HALF_BIT - 1);
                        end
                    end
                    RX_START: begin
                        if (cnt == '0) begin
                            if (!serial_in) begin
                                state <= RX_DATA;
                                cnt   <= CNT_W'(CLK_PER_BIT - 1);
                                idx   <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt == '0) begin
                            shreg <= {serial_in, shreg[DATA_BITS-1:1]};
                            cnt   <= CNT_W'(CLK_PER_BIT - 1);
                            if (idx == IDX_W'(DATA_BITS - 1)) begin
                                byte_vld <= 1'b1;
                                state    <= RX_STOP;
                            end else begin
                                idx <= idx + IDX_W'(1);
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cnt == '0) state <= RX_IDLE;
                        else           cnt   <= cnt - CNT_W'(1);
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign byte_q = shreg;
endmodule

// File: rtl/cbr_readout.sv
// Holds the received byte in a shift register that the host drains one
// bit per read edge, oldest bit first. It also drives the self-timed
// ready strobe, which an early read clears, and the sticky overrun flag.
// Assumes load and rd_rise are single-cycle pulses in the clk domain.
module cbr_readout #(
    parameter int DATA_BITS = 8,
    parameter int HALF_BIT  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [DATA_BITS-1:0]         byte_in,
    input  logic                         rd_rise,
    output logic                         data_out,
    output logic                         rdy_n,
    output logic                         overrun,
    output logic [$clog2(DATA_BITS+1)-1:0] bits_left
);
    localparam int LEFT_W = $clog2(DATA_BITS + 1);
    localparam int TMR_W  = (HALF_BIT > 2) ? $clog2(HALF_BIT) : 1;

    logic [DATA_BITS-1:0] shreg;
    logic [LEFT_W-1:0]    left;
    logic                 data_q;
    logic                 rdy_q;
    logic [TMR_W-1:0]     tmr;
    logic                 ovr_q;

    // Load a new byte, or shift one bit out per host read edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            left   <= '0;
            data_q <= 1'b1;
        end else if (load) begin
            shreg <= byte_in;
            left  <= LEFT_W'(DATA_BITS);
        end else if (rd_rise && left != '0) begin
            data_q <= shreg[0];
            shreg  <= {1'b0, shreg[DATA_BITS-1:1]};
            left   <= left - LEFT_W'(1);
        end
    end

    // Ready strobe: set on load, cleared by a read edge or by the half-bit timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            tmr   <= '0;
        end else if (load) begin
            rdy_q <= 1'b1;
            tmr   <= TMR_W'(HALF_BIT - 1);
        end else if (rdy_q) begin
            if (rd_rise || tmr == '0) rdy_q <= 1'b0;
            else                      tmr   <= tmr - TMR_W'(1);
        end
    end

    // Sticky overrun: a load while unread bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (load && left != '0) ovr_q <= 1'b1;
    end

    assign data_out  = data_q;
    assign rdy_n     = ~rdy_q;
    assign overrun   = ovr_q;
    assign bits_left = left;
endmodule

// File: rtl/cid_byte_reader.sv
// Top level of the buffered byte readout. Frame reception is gated by
// carrier_ok. The host read clock is synchronized into clk, and the
// readout stage serves the host. Assumes demod_bit is synchronous to clk
// and that clk runs at least 4x the host read rate.
module cid_byte_reader #(
    parameter int CLK_PER_BIT = 41667,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_ok,
    input  logic demod_bit,
    input  logic host_rd_clk,
    output logic data_out,
    output logic rdy_n,
    output logic overrun
);
    localparam int HALF_BIT = CLK_PER_BIT / 2;
    localparam int LEFT_W   = $clog2(DATA_BITS + 1);

    logic                 byte_vld;
    logic [DATA_BITS-1:0] rx_byte;
    logic                 host_rise;
    logic                 load;
    logic [LEFT_W-1:0]    bits_left;

    cbr_frame_rx #(
        .CLK_PER_BIT(CLK_PER_BIT),
        .DATA_BITS  (DATA_BITS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier_ok(carrier_ok),
        .serial_in (demod_bit),
        .byte_vld  (byte_vld),
        .byte_q    (rx_byte)
    );

    cbr_clk_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(host_rd_clk),
        .rise    (host_rise)
    );

    // A byte is only taken while carrier is still valid.
    assign load = byte_vld & carrier_ok;

    cbr_readout #(
        .DATA_BITS(DATA_BITS),
        .HALF_BIT (HALF_BIT)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .byte_in  (rx_byte),
        .rd_rise  (host_rise),
        .data_out (data_out),
        .rdy_n    (rdy_n),
        .overrun  (overrun),
        .bits_left(bits_left)
    );
endmodule

// File: rtl/cbr_checker.sv
// Protocol checks for cid_byte_reader, bound into every instance.
module cbr_checker #(
    parameter int HALF_BIT = 8,
    parameter int LEFT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              carrier_ok,
    input logic              host_rise,
    input logic              load,
    input logic [LEFT_W-1:0] bits_left,
    input logic              data_out,
    input logic              rdy_n,
    input logic              overrun
);
    logic was_rst;
    int   low_cnt;

    // Remember that the previous edge was in reset; check the reset values.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (was_rst) begin
            assert_reset_state_R1: assert (rdy_n && !overrun && data_out);
        end
    end

    // Count consecutive low cycles of the ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || rdy_n) low_cnt <= 0;
        else                 low_cnt <= low_cnt + 1;
    end

    assert_rdy_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> low_cnt < HALF_BIT);

    assert_rdy_needs_carrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(carrier_ok));

    assert_data_moves_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> $past(host_rise));

    assert_early_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rise && !rdy_n && !load) |=> rdy_n);

    assert_extra_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rise && bits_left == '0 && !load) |=> $stable(data_out));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind cid_byte_reader cbr_checker #(
    .HALF_BIT(HALF_BIT),
    .LEFT_W  (LEFT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_ok(carrier_ok),
    .host_rise (host_rise),
    .load      (load),
    .bits_left (bits_left),
    .data_out  (data_out),
    .rdy_n     (rdy_n),
    .overrun   (overrun)
);

// File: tb/tb_cid_byte_reader.sv
module tb_cid_byte_reader;
    localparam int CPB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier_ok = 1'b0;
    logic demod_bit = 1'b1;
    logic host_rd_clk = 1'b0;
    logic data_out, rdy_n, overrun;

    int checks = 0;
    int errors = 0;
    int low_cycles = 0;
    int falls = 0;
    logic prev_rdy = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cid_byte_reader #(.CLK_PER_BIT(CPB), .DATA_BITS(8), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .demod_bit(demod_bit),
        .host_rd_clk(host_rd_clk), .data_out(data_out), .rdy_n(rdy_n), .overrun(overrun)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rdy_n) low_cycles = low_cycles + 1;
            if (prev_rdy && !rdy_n) falls = falls + 1;
            prev_rdy = rdy_n;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        low_cycles = 0;
        falls = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Start bit, then payload bits 0..7. Then wait (up to 24 cycles) for the
    // strobe and return the line to idle.
    task automatic rx_byte(input logic [7:0] b, output bit seen);
        seen = 1'b0;
        @(negedge clk);
        demod_bit = 1'b0;
        idle(CPB);
        for (int i = 0; i < 7; i++) begin
            demod_bit = b[i];
            idle(CPB);
        end
        demod_bit = b[7];
        for (int i = 0; i < 24 && !seen; i++) begin
            @(negedge clk);
            if (!rdy_n) seen = 1'b1;
        end
        demod_bit = 1'b1;
    endtask

    task automatic host_pulse();
        host_rd_clk = 1'b1;
        idle(4);
        host_rd_clk = 1'b0;
        idle(4);
    endtask

    task automatic read_check(input logic [7:0] exp, input string tag);
        for (int i = 0; i < 8; i++) begin
            host_pulse();
            check(tag, int'(data_out), int'(exp[i]));
        end
    endtask

    task automatic t_reset();
        idle(1);
        check("R1 rdy_n", int'(rdy_n), 1);
        check("R1 overrun", int'(overrun), 0);
        check("R1 data_out", int'(data_out), 1);
    endtask

    // R2/R3/R4/R6: several patterns, each read fully after the strobe expires.
    task automatic t_patterns();
        logic [7:0] pats[3] = '{8'hA5, 8'h3C, 8'h81};
        bit seen;
        foreach (pats[k]) begin
            clear_mon();
            rx_byte(pats[k], seen);
            check("R3 strobe seen", int'(seen), 1);
            idle(2 * CPB);
            @(posedge clk);
            check("R6 strobe width", low_cycles, CPB / 2);
            check("R3 one strobe", falls, 1);
            read_check(pats[k], "R2 R4 bit order");
        end
    endtask

    // R5: reading inside the strobe window clears it early. R7: extra reads ignored.
    task automatic t_early_clear();
        bit seen;
        clear_mon();
        rx_byte(8'hC6, seen);
        check("R5 strobe seen", int'(seen), 1);
        host_rd_clk = 1'b1;
        idle(4);
        check("R5 cleared by read", int'(rdy_n), 1);
        check("R4 first bit", int'(data_out), 0);
        host_rd_clk = 1'b0;
        idle(4);
        @(posedge clk);
        check("R5 shortened", int'(low_cycles < CPB / 2), 1);
        for (int i = 1; i < 8; i++) begin
            host_pulse();
            check("R4 later bits", int'(data_out), int'(((8'hC6) >> i) & 1));
        end
        for (int i = 0; i < 3; i++) begin
            host_pulse();
            check("R7 extra read data", int'(data_out), 1);
            check("R7 extra read rdy", int'(rdy_n), 1);
        end
    endtask

    // R8: frame without carrier is ignored; the stored byte survives.
    task automatic t_carrier();
        bit seen;
        rx_byte(8'h5A, seen);
        idle(2 * CPB);
        carrier_ok = 1'b0;
        clear_mon();
        rx_byte(8'hF0, seen);
        idle(2 * CPB);
        @(posedge clk);
        check("R8 no strobe", falls, 0);
        @(negedge clk);
        carrier_ok = 1'b1;
        idle(4);
        read_check(8'h5A, "R8 byte kept");
        check("R8 no overrun", int'(overrun), 0);
    endtask

    // R10: a short low glitch is not a start bit.
    task automatic t_glitch();
        clear_mon();
        @(negedge clk);
        demod_bit = 1'b0;
        idle(3);
        demod_bit = 1'b1;
        idle(3 * CPB);
        @(posedge clk);
        check("R10 no strobe", falls, 0);
        host_pulse();
        check("R10 data unchanged", int'(data_out), 0);
    endtask

    // R9: second byte overwrites an unread first byte and sets a sticky flag.
    task automatic t_overrun();
        bit seen;
        rx_byte(8'h12, seen);
        idle(2 * CPB);
        check("R9 no overrun yet", int'(overrun), 0);
        rx_byte(8'hB7, seen);
        idle(2 * CPB);
        check("R9 overrun set", int'(overrun), 1);
        read_check(8'hB7, "R9 newest byte");
        rx_byte(8'h0F, seen);
        idle(2 * CPB);
        read_check(8'h0F, "R9 next byte");
        check("R9 overrun sticky", int'(overrun), 1);
    endtask

    initial begin
        idle(5);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        carrier_ok = 1'b1;
        idle(2 * CPB);
        t_patterns();
        idle(2 * CPB);
        t_early_clear();
        idle(2 * CPB);
        t_carrier();
        t_glitch();
        idle(2 * CPB);
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule